// File: doc/BRIEF.md
# Prioritised Interrupt Distributor

This block collects interrupt requests from hardware source pins and from software trigger writes. It keeps per-interrupt configuration for enable, priority, trigger type and CPU routing, and presents to each of several CPU interfaces the most urgent interrupt that is pending, enabled and routed to that CPU. Configuration goes through a plain word-wide register bus. Every field is byte- or bit-indexed by interrupt ID, so software can update one interrupt with a single word write.

IDs 0 to 15 are software-raised and are pending separately per CPU. IDs 16 to 31 come from source pins and go to every CPU. IDs 32 and up come from source pins and go only to the CPUs named in their target mask.

Writes take effect at the clock edge where `wr_en` is high. Reads are combinational from `addr`. The bus has no back-pressure: every write is accepted in its cycle. The per-CPU results are plain registered outputs.

Word address map (8-bit word address):

| Word | Use |
|---|---|
| 0x00 | bit 0 global forward enable |
| 0x01 | software trigger: bits[3:0] ID, bits[23:16] CPU list |
| 0x10+n | enable set, reads enable state |
| 0x18+n | enable clear, reads enable state |
| 0x20+n | pending clear |
| 0x40+n | priority |
| 0x80+n | trigger config |
| 0xC0+n | CPU target |

Top module: `irq_dist`

## Requirements
- R1: After reset every priority byte reads 0xA0, config fields of IDs 16 and up read 01, all enables read 0, the global enable is 0, and every CPU reports ID 1023 with priority 0xFF and `cpu_irq` low.
- R2: Priority of ID i sits in word 0x40+i/4, byte lane i mod 4. Only bits 7:3 are kept. Bits 2:0 read as zero. A lower value is more urgent.
- R3: Trigger config of ID i sits in word 0x80+i/16, bits 2*(i mod 16)+1:2*(i mod 16). IDs 0 to 15 always read 10 and ignore writes. Other IDs read bit 0 as 1. Writing 1 to the upper bit selects rising-edge (11), and writing 0 selects active-high level (01).
- R4: Enable of ID i is bit i mod 32 of word 0x10+i/32 (set) and 0x18+i/32 (clear). Writing 1 sets or clears the bit, writing 0 leaves it unchanged, and both words read the current enable state.
- R5: A level-configured source is pending while its pin is high and stops being pending when the pin goes low.
- R6: An edge-configured source latches pending on a rising edge and stays pending after the pin falls. Writing 1 to bit i mod 32 of word 0x20+i/32 clears the latch.
- R7: A write to word 0x01 raises ID bits[3:0] as pending for each CPU c whose bit 16+c is set. The same pending-clear word and bit clears it for all CPUs.
- R8: IDs 32 and up reach only CPUs whose bit is set in the target byte (word 0xC0+i/4, lane i mod 4, bit c for CPU c). IDs 16 to 31 reach every CPU.
- R9: A disabled interrupt keeps its pending state and is not forwarded. It is forwarded after it is enabled again.
- R10: With the global enable at 0, no CPU sees an interrupt, while configuration writes still take effect.
- R11: Each CPU reports the qualifying ID with the smallest priority value, and the lowest ID among equal priorities. `cpu_irq` is high exactly when an ID is reported.
- R12: Outputs update one clock after a register write and two clocks after a source pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| wr_en | input | 1 | write strobe |
| addr | input | 8 | word address |
| wdata | input | 32 | write data |
| rdata | output | 32 | read data for addr (combinational) |
| hw_irq | input | NUM_IRQ-16 | source pins for IDs 16 to NUM_IRQ-1 |
| cpu_irq | output | NUM_CPU | CPU c has a qualifying interrupt |
| cpu_id | output | 10*NUM_CPU | selected ID per CPU (1023 when none) |
| cpu_prio | output | 8*NUM_CPU | selected priority per CPU (0xFF when none) |

## Verification
A register write lands at the edge where `wr_en` is high, and the selection register picks up the new state one edge later. The bench therefore samples CPU outputs on the falling edge that follows one further rising edge after each write. A source pin passes through an input register before selection, so pin changes are sampled two rising edges later. One check sits exactly one edge after a pin change to confirm the output has not yet moved. Register reads are combinational and are checked within the same low clock phase in which the address is applied.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  localparam int ID_W    = 10;
  localparam int SPUR_ID = 1023;
  localparam int SGI_N   = 16;
  localparam int SHR_LO  = 32;
  localparam logic [7:0] A_CTRL   = 8'h00;
  localparam logic [7:0] A_SWTRIG = 8'h01;
  localparam logic [7:0] A_ENSET  = 8'h10;
  localparam logic [7:0] A_ENCLR  = 8'h18;
  localparam logic [7:0] A_PCLR   = 8'h20;
  localparam logic [7:0] A_PRIO   = 8'h40;
  localparam logic [7:0] A_CFG    = 8'h80;
  localparam logic [7:0] A_TGT    = 8'hC0;
endpackage

// File: rtl/irq_dist_cfg.sv
module irq_dist_cfg
  import irq_dist_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 8
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    wr_en,
  input  logic [7:0]                              addr,
  input  logic [31:0]                             wdata,
  output logic [31:0]                             rdata,
  output logic                                    gen,
  output logic [NUM_IRQ-1:0]                      en,
  output logic [NUM_IRQ-1:0][4:0]                 prio,
  output logic [NUM_IRQ-1:SGI_N]                  edge_cfg,
  output logic [NUM_IRQ-1:SHR_LO][NUM_CPU-1:0]    tgt,
  output logic                                    sgi_hit,
  output logic [3:0]                              sgi_id,
  output logic [NUM_CPU-1:0]                      sgi_cpus,
  output logic [NUM_IRQ-1:0]                      pclr
);
  localparam int EN_WORDS = NUM_IRQ / 32;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen      <= 1'b0;
      en       <= '0;
      edge_cfg <= '0;
      tgt      <= '0;
      for (int i = 0; i < NUM_IRQ; i++) prio[i] <= 5'd20;  // byte 0xA0
    end else if (wr_en) begin
      if (addr == A_CTRL) gen <= wdata[0];
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (addr == A_ENSET + 8'(i / 32) && wdata[i % 32]) en[i] <= 1'b1;
        if (addr == A_ENCLR + 8'(i / 32) && wdata[i % 32]) en[i] <= 1'b0;
        if (addr == A_PRIO + 8'(i / 4)) prio[i] <= wdata[(i % 4) * 8 + 3 +: 5];
      end
      for (int i = SGI_N; i < NUM_IRQ; i++)
        if (addr == A_CFG + 8'(i / 16)) edge_cfg[i] <= wdata[(i % 16) * 2 + 1];
      for (int i = SHR_LO; i < NUM_IRQ; i++)
        if (addr == A_TGT + 8'(i / 4)) tgt[i] <= wdata[(i % 4) * 8 +: NUM_CPU];
    end
  end

  // write-side pulses consumed by the pending store
  assign sgi_hit  = wr_en && (addr == A_SWTRIG);
  assign sgi_id   = wdata[3:0];
  assign sgi_cpus = wdata[16 +: NUM_CPU];

  always_comb begin
    pclr = '0;
    for (int w = 0; w < EN_WORDS; w++)
      if (wr_en && addr == A_PCLR + 8'(w)) pclr[w*32 +: 32] = wdata;
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL) rdata[0] = gen;
    for (int w = 0; w < EN_WORDS; w++)
      if (addr == A_ENSET + 8'(w) || addr == A_ENCLR + 8'(w)) rdata = en[w*32 +: 32];
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (addr == A_PRIO + 8'(i / 4)) rdata[(i % 4) * 8 + 3 +: 5] = prio[i];
      if (i < SGI_N && addr == A_CFG + 8'(i / 16)) rdata[(i % 16) * 2 +: 2] = 2'b10;
    end
    for (int i = SGI_N; i < NUM_IRQ; i++)
      if (addr == A_CFG + 8'(i / 16)) rdata[(i % 16) * 2 +: 2] = {edge_cfg[i], 1'b1};
    for (int i = SHR_LO; i < NUM_IRQ; i++)
      if (addr == A_TGT + 8'(i / 4)) rdata[(i % 4) * 8 +: NUM_CPU] = tgt[i];
  end
endmodule

// File: rtl/irq_dist_pend.sv
module irq_dist_pend
  import irq_dist_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_IRQ-1:SGI_N]            hw_irq,
  input  logic [NUM_IRQ-1:SGI_N]            edge_cfg,
  input  logic                              sgi_hit,
  input  logic [3:0]                        sgi_id,
  input  logic [NUM_CPU-1:0]                sgi_cpus,
  input  logic [NUM_IRQ-1:0]                pclr,
  output logic [NUM_IRQ-1:SGI_N]            hw_pend,
  output logic [SGI_N-1:0][NUM_CPU-1:0]     sgi_pend
);
  for (genvar i = 0; i < SGI_N; i++) begin : g_soft
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      always_ff @(posedge clk) begin
        if (!rst_n) sgi_pend[i][c] <= 1'b0;
        else sgi_pend[i][c] <= (sgi_pend[i][c] & ~pclr[i])
                             | (sgi_hit && sgi_id == 4'(i) && sgi_cpus[c]);
      end
    end
  end

  for (genvar i = SGI_N; i < NUM_IRQ; i++) begin : g_hw
    logic pin_q, lat;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pin_q <= 1'b0;
        lat   <= 1'b0;
      end else begin
        pin_q <= hw_irq[i];
        lat   <= (lat & ~pclr[i]) | (edge_cfg[i] & hw_irq[i] & ~pin_q);
      end
    end
    assign hw_pend[i] = edge_cfg[i] ? lat : pin_q;
  end
endmodule

// File: rtl/irq_dist_pick.sv
module irq_dist_pick
  import irq_dist_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_IRQ-1:0]      cand,
  input  logic [NUM_IRQ-1:0][4:0] prio,
  output logic                    irq_o,
  output logic [ID_W-1:0]         id_o,
  output logic [7:0]              prio_o
);
  logic [5:0]      best_p;
  logic [ID_W-1:0] best_id;

  // strict compare in ascending ID order keeps the lowest ID on a tie
  always_comb begin
    best_p  = 6'd32;
    best_id = ID_W'(SPUR_ID);
    for (int i = 0; i < NUM_IRQ; i++)
      if (cand[i] && {1'b0, prio[i]} < best_p) begin
        best_p  = {1'b0, prio[i]};
        best_id = ID_W'(i);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o  <= 1'b0;
      id_o   <= ID_W'(SPUR_ID);
      prio_o <= 8'hFF;
    end else begin
      irq_o  <= !best_p[5];
      id_o   <= best_id;
      prio_o <= best_p[5] ? 8'hFF : {best_p[4:0], 3'b000};
    end
  end
endmodule

// File: rtl/irq_dist.sv
module irq_dist
  import irq_dist_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [7:0]              addr,
  input  logic [31:0]             wdata,
  output logic [31:0]             rdata,
  input  logic [NUM_IRQ-1:16]     hw_irq,
  output logic [NUM_CPU-1:0]      cpu_irq,
  output logic [NUM_CPU*10-1:0]   cpu_id,
  output logic [NUM_CPU*8-1:0]    cpu_prio
);
  logic                                 gen_w;
  logic [NUM_IRQ-1:0]                   en_w;
  logic [NUM_IRQ-1:0][4:0]              prio_w;
  logic [NUM_IRQ-1:SGI_N]               edge_w;
  logic [NUM_IRQ-1:SHR_LO][NUM_CPU-1:0] tgt_w;
  logic                                 sgi_hit_w;
  logic [3:0]                           sgi_id_w;
  logic [NUM_CPU-1:0]                   sgi_cpus_w;
  logic [NUM_IRQ-1:0]                   pclr_w;
  logic [NUM_IRQ-1:SGI_N]               hw_pend_w;
  logic [SGI_N-1:0][NUM_CPU-1:0]        sgi_pend_w;
  logic [NUM_CPU-1:0][NUM_IRQ-1:0]      cand_w;

  irq_dist_cfg #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .gen(gen_w), .en(en_w), .prio(prio_w), .edge_cfg(edge_w),
    .tgt(tgt_w), .sgi_hit(sgi_hit_w), .sgi_id(sgi_id_w), .sgi_cpus(sgi_cpus_w),
    .pclr(pclr_w)
  );

  irq_dist_pend #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_pend (
    .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .edge_cfg(edge_w),
    .sgi_hit(sgi_hit_w), .sgi_id(sgi_id_w), .sgi_cpus(sgi_cpus_w),
    .pclr(pclr_w), .hw_pend(hw_pend_w), .sgi_pend(sgi_pend_w)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_id
      if (i < SGI_N) begin : g_sgi
        assign cand_w[c][i] = gen_w & en_w[i] & sgi_pend_w[i][c];
      end else if (i < SHR_LO) begin : g_all
        assign cand_w[c][i] = gen_w & en_w[i] & hw_pend_w[i];
      end else begin : g_routed
        assign cand_w[c][i] = gen_w & en_w[i] & hw_pend_w[i] & tgt_w[i][c];
      end
    end

    irq_dist_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
      .clk(clk), .rst_n(rst_n), .cand(cand_w[c]), .prio(prio_w),
      .irq_o(cpu_irq[c]), .id_o(cpu_id[c*10 +: 10]), .prio_o(cpu_prio[c*8 +: 8])
    );
  end
endmodule

// File: rtl/irq_dist_chk.sv
module irq_dist_chk
  import irq_dist_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [7:0]            addr,
  input logic [31:0]           wdata,
  input logic [31:0]           rdata,
  input logic [NUM_CPU-1:0]    cpu_irq,
  input logic [NUM_CPU*10-1:0] cpu_id,
  input logic [NUM_CPU*8-1:0]  cpu_prio,
  input logic                  gen,
  input logic [NUM_IRQ-1:0]    en
);
  localparam int IW = $clog2(NUM_IRQ);
  logic [NUM_IRQ-1:0] en_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) en_prev <= '0;
    else        en_prev <= en;
  end

  // R10
  gen_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gen |=> cpu_irq == '0);

  // R3
  sgi_cfg_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr == A_CFG |-> rdata == 32'hAAAA_AAAA);

  // R2
  prio_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr[7:6] == 2'b01 |-> (rdata & 32'h0707_0707) == 32'h0);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
    // R11
    spur_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_irq[c] |-> cpu_id[c*10 +: 10] == 10'(SPUR_ID) && cpu_prio[c*8 +: 8] == 8'hFF);
    // R11
    id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq[c] |-> cpu_id[c*10 +: 10] < 10'(NUM_IRQ) && cpu_prio[c*8 +: 3] == 3'b000);
    // R9
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq[c] |-> en_prev[cpu_id[c*10 +: IW]]);
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_i
    // R4
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_ENCLR + 8'(i / 32) && wdata[i % 32]) |=> !en[i]);
  end
endmodule

bind irq_dist irq_dist_chk #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .cpu_irq(cpu_irq), .cpu_id(cpu_id), .cpu_prio(cpu_prio),
  .gen(gen_w), .en(en_w)
);

// File: tb/irq_dist_test.sv
`timescale 1ns/1ps
module irq_dist_test;
  localparam int NI = 64;
  localparam int NC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NI-1:16] hw_irq = '0;
  logic [NC-1:0] cpu_irq;
  logic [NC*10-1:0] cpu_id;
  logic [NC*8-1:0] cpu_prio;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  irq_dist #(.NUM_IRQ(NI), .NUM_CPU(NC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .hw_irq(hw_irq), .cpu_irq(cpu_irq), .cpu_id(cpu_id),
    .cpu_prio(cpu_prio)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpu_chk(input string req, input int c, input int id, input int pr);
    chk({req, " id"}, 32'(cpu_id[c*10 +: 10]), 32'(id));
    chk({req, " prio"}, 32'(cpu_prio[c*8 +: 8]), 32'(pr));
    chk({req, " irq"}, 32'(cpu_irq[c]), 32'(id != 1023));
  endtask

  task automatic t_reset();
    rd_chk("R1 prio", 8'h40, 32'hA0A0_A0A0);
    rd_chk("R1 cfg16", 8'h81, 32'h5555_5555);
    rd_chk("R1 cfg32", 8'h82, 32'h5555_5555);
    rd_chk("R1 en", 8'h11, 32'h0);
    rd_chk("R1 ctrl", 8'h00, 32'h0);
    for (int c = 0; c < NC; c++) cpu_chk("R1 out", c, 1023, 8'hFF);
  endtask

  task automatic t_prio();
    wr(8'h4A, 32'h1234_5677);
    rd_chk("R2 masked", 8'h4A, 32'h1030_5070);
    rd_chk("R2 other word", 8'h49, 32'hA0A0_A0A0);
  endtask

  task automatic t_cfg();
    wr(8'h80, 32'h0);
    rd_chk("R3 sgi fixed", 8'h80, 32'hAAAA_AAAA);
    wr(8'h82, 32'hFFFF_FFFF);
    rd_chk("R3 all edge", 8'h82, 32'hFFFF_FFFF);
    wr(8'h82, 32'h0);
    rd_chk("R3 all level", 8'h82, 32'h5555_5555);
    wr(8'h82, 32'h000C_0000);
    rd_chk("R3 id41 edge", 8'h82, 32'h555D_5555);
  endtask

  task automatic t_enable();
    wr(8'h11, 32'h0000_0101);
    rd_chk("R4 set view", 8'h11, 32'h101);
    rd_chk("R4 clr view", 8'h19, 32'h101);
    wr(8'h19, 32'h1);
    rd_chk("R4 clear one", 8'h11, 32'h100);
    wr(8'h19, 32'h0);
    rd_chk("R4 zero clr", 8'h11, 32'h100);
    wr(8'h11, 32'h0);
    rd_chk("R4 zero set", 8'h11, 32'h100);
  endtask

  task automatic t_level();
    wr(8'h00, 32'h1);
    wr(8'hCA, 32'h0000_0402);  // ID40 -> cpu1, ID41 -> cpu2
    settle(1);
    hw_irq[40] = 1'b1;
    settle(1);
    cpu_chk("R12 one clock", 1, 1023, 8'hFF);
    settle(1);
    cpu_chk("R5 level", 1, 40, 8'h70);
    cpu_chk("R8 not targeted", 0, 1023, 8'hFF);
    hw_irq[40] = 1'b0;
    settle(2);
    cpu_chk("R5 level drop", 1, 1023, 8'hFF);
  endtask

  task automatic t_edge();
    wr(8'h11, 32'h0000_0200);
    hw_irq[41] = 1'b1;
    settle(1);
    hw_irq[41] = 1'b0;
    settle(1);
    cpu_chk("R6 edge latch", 2, 41, 8'h50);
    settle(2);
    cpu_chk("R6 held", 2, 41, 8'h50);
    wr(8'h21, 32'h0000_0200);
    settle(1);
    cpu_chk("R6 cleared", 2, 1023, 8'hFF);
    wr(8'h19, 32'hFFFF_FFFF);
  endtask

  task automatic t_sgi();
    wr(8'h10, 32'h8);
    wr(8'h40, 32'h08A0_A0A0);
    wr(8'h01, 32'h0081_0003);
    settle(1);
    cpu_chk("R7 cpu0", 0, 3, 8'h08);
    cpu_chk("R7 cpu7", 7, 3, 8'h08);
    cpu_chk("R7 cpu1", 1, 1023, 8'hFF);
    wr(8'h20, 32'h8);
    settle(1);
    cpu_chk("R7 clear", 0, 1023, 8'hFF);
  endtask

  task automatic t_order();
    wr(8'h10, 32'h28);
    wr(8'h01, 32'h0010_0003);
    wr(8'h01, 32'h0010_0005);
    settle(1);
    cpu_chk("R11 lower value", 4, 3, 8'h08);
    wr(8'h40, 32'hA0A0_A0A0);
    settle(1);
    cpu_chk("R11 tie lowest id", 4, 3, 8'hA0);
    wr(8'h41, 32'hA0A0_00A0);
    settle(1);
    cpu_chk("R11 urgent wins", 4, 5, 8'h00);
    wr(8'h20, 32'hFFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h41, 32'hA0A0_A0A0);
  endtask

  task automatic t_disable();
    wr(8'h01, 32'h0020_0006);
    settle(1);
    cpu_chk("R9 disabled", 5, 1023, 8'hFF);
    wr(8'h10, 32'h40);
    settle(1);
    cpu_chk("R9 reenabled", 5, 6, 8'hA0);
  endtask

  task automatic t_global();
    wr(8'h00, 32'h0);
    settle(1);
    cpu_chk("R10 gated", 5, 1023, 8'hFF);
    wr(8'h41, 32'h0);
    rd_chk("R10 cfg accepted", 8'h41, 32'h0);
    wr(8'h00, 32'h1);
    settle(1);
    cpu_chk("R10 restored", 5, 6, 8'h00);
    wr(8'h20, 32'hFFFF);
    wr(8'h18, 32'hFFFF_FFFF);
  endtask

  task automatic t_broadcast();
    wr(8'h10, 32'h0010_0000);
    hw_irq[20] = 1'b1;
    settle(2);
    cpu_chk("R8 all cpu0", 0, 20, 8'hA0);
    cpu_chk("R8 all cpu7", 7, 20, 8'hA0);
    hw_irq[20] = 1'b0;
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'hCA, 32'h0);
    wr(8'h11, 32'h100);
    hw_irq[40] = 1'b1;
    settle(2);
    for (int c = 0; c < NC; c++) cpu_chk("R8 empty mask", c, 1023, 8'hFF);
    hw_irq[40] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle(1);
    t_reset();
    t_prio();
    t_cfg();
    t_enable();
    t_level();
    t_edge();
    t_sgi();
    t_order();
    t_disable();
    t_global();
    t_broadcast();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule